// File: doc/BRIEF.md
# Character dot pattern output composer

This block builds the dot and symbol drive for the digit that a display scanner is currently lighting. Each digit position stores an 8-bit character code and a 2-bit symbol value. The block fetches them, then turns the code into a 5-column by 7-row dot pattern. Codes 00h to 07h pick one of eight user-writable pattern slots. Every other code picks a fixed glyph from a small built-in table. The fixed table holds a placeholder font that can be computed from the code.

A pattern arrives as five 7-bit column bytes. The block spreads these bytes onto 35 dot lines in column-major order. The symbol bits pass straight through with no lookup. A global light mode is applied last. It can blank every output, or force every output high, and forcing high takes priority.

The fetch pipeline runs all the time from the digit index. The output register loads only on the scan timer's digit-advance strobe. The scanner presents the index of the next digit and holds it steady. It then pulses the strobe, and the new digit appears on the outputs.

Top module: `dot_composer`

## Requirements
- R1: A synchronous reset drives every dot and symbol output low, and they stay low until the first cycle in which `adv` is high.
- R2: A character code from 00h to 07h selects user pattern slot code[2:0]. The slot address goes out on `upat_raddr`, and the word returned on `upat_rdata` is what gets displayed.
- R3: A character code from 08h to FFh selects a fixed glyph. Column k (0..4) of that glyph is the 8-bit code rotated left by k places, keeping its low 7 bits.
- R4: Column k, row r (r = 0..6) of a pattern drives dot line `seg_o[k + 5*r]`. In a user pattern word, column k occupies bits [7k+6:7k], with row r at bit 7k+r.
- R5: In normal light mode, `sym_o` equals the 2-bit symbol value stored for the displayed digit, unchanged.
- R6: When `light_lo`=1 and `light_hi`=0 at a strobe, all 35 dot outputs and both symbol outputs are loaded low.
- R7: When `light_hi`=1 at a strobe, all dot and symbol outputs are loaded high, whatever the value of `light_lo`.
- R8: The outputs change only on a clock edge at which `adv` is high. At that edge they take the digit given by `digit_idx`, provided `digit_idx` was held for the three edges ending at that one. Memory reads return data one cycle after their address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Digit-advance strobe from the scan timer |
| digit_idx | input | 4 | Index of the digit to be shown at the next strobe |
| code_raddr | output | 4 | Read address into the code and symbol memories |
| code_rdata | input | 8 | Character code read back, one cycle after the address |
| sym_rdata | input | 2 | Symbol bits read back, one cycle after the address |
| upat_raddr | output | 3 | Read address into the user pattern memory |
| upat_rdata | input | 35 | User pattern word read back (five 7-bit columns), one cycle after the address |
| light_lo | input | 1 | Light control: force all outputs off |
| light_hi | input | 1 | Light control: force all outputs on (takes priority) |
| seg_o | output | 35 | Dot line outputs, bit n drives dot line n+1 |
| sym_o | output | 2 | Symbol outputs |

## Verification
A digit index must be presented before the first of three edges. The code read completes at the first edge, and the user pattern read and stage capture complete at the second. The output loads at the third edge, when the strobe is high. The bench therefore sets the index at a falling edge and raises `adv` only after two rising edges have passed. It compares outputs at the falling edge that follows the loading edge. Hold checks alter the index and the memory contents, then let several strobe-free cycles pass, and confirm at a falling edge that the outputs did not move.

// File: rtl/dc_pkg.sv
package dc_pkg;

    localparam int NUM_COLS    = 5;
    localparam int NUM_ROWS    = 7;
    localparam int NUM_DOTS    = NUM_COLS * NUM_ROWS;
    localparam int CODE_W      = 8;
    localparam int SYM_W       = 2;
    localparam int NUM_DIGITS  = 16;
    localparam int DIGIT_W     = $clog2(NUM_DIGITS);
    localparam int USER_SLOTS  = 8;
    localparam int SLOT_W      = $clog2(USER_SLOTS);

    typedef logic [NUM_ROWS-1:0]              col_t;
    typedef col_t [NUM_COLS-1:0]              cols_t;
    typedef logic [NUM_DOTS-1:0]              dots_t;
    typedef logic [CODE_W-1:0]                code_t;
    typedef logic [SYM_W-1:0]                 sym_t;

    typedef enum logic [1:0] {
        LM_NORMAL = 2'd0,
        LM_DARK   = 2'd1,
        LM_BRIGHT = 2'd2
    } light_e;

    typedef struct packed {
        code_t code;
        sym_t  sym;
    } fetch_t;

    typedef struct packed {
        dots_t dots;
        sym_t  sym;
    } drive_t;

    // Bright wins over dark.
    function automatic light_e light_decode(logic lo, logic hi);
        if (hi)
            return LM_BRIGHT;
        else if (lo)
            return LM_DARK;
        else
            return LM_NORMAL;
    endfunction

    function automatic logic is_user_code(code_t c);
        return (c >> SLOT_W) == '0;
    endfunction

    // Placeholder font: column k is the code rotated left by k.
    function automatic col_t glyph_col(code_t c, int unsigned k);
        code_t r;
        case (k)
            0:       r = c;
            1:       r = {c[6:0], c[7]};
            2:       r = {c[5:0], c[7:6]};
            3:       r = {c[4:0], c[7:5]};
            default: r = {c[3:0], c[7:4]};
        endcase
        return r[NUM_ROWS-1:0];
    endfunction

endpackage

// File: rtl/dc_fetch.sv
module dc_fetch
    import dc_pkg::*;
(
    input  logic               clk,
    input  logic [DIGIT_W-1:0] digit_idx,
    input  code_t              code_rdata,
    input  sym_t               sym_rdata,
    output logic [DIGIT_W-1:0] code_raddr,
    output logic [SLOT_W-1:0]  upat_raddr,
    output fetch_t             stage_q
);

    assign code_raddr = digit_idx;
    assign upat_raddr = code_rdata[SLOT_W-1:0];

    // Aligns code and symbol with the user pattern read that returns
    // at the same edge.
    always_ff @(posedge clk) begin
        stage_q.code <= code_rdata;
        stage_q.sym  <= sym_rdata;
    end

endmodule

// File: rtl/dc_glyph_rom.sv
module dc_glyph_rom
    import dc_pkg::*;
(
    input  code_t code,
    output cols_t cols
);

    for (genvar k = 0; k < NUM_COLS; k++) begin : g_col
        assign cols[k] = glyph_col(code, k);
    end

endmodule

// File: rtl/dc_dot_map.sv
module dc_dot_map
    import dc_pkg::*;
(
    input  cols_t cols,
    output dots_t dots
);

    for (genvar k = 0; k < NUM_COLS; k++) begin : g_col
        for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
            assign dots[k + NUM_COLS*r] = cols[k][r];
        end
    end

endmodule

// File: rtl/dc_light.sv
module dc_light
    import dc_pkg::*;
(
    input  light_e mode,
    input  drive_t raw,
    output drive_t forced
);

    always_comb begin
        case (mode)
            LM_BRIGHT: forced = '1;
            LM_DARK:   forced = '0;
            default:   forced = raw;
        endcase
    end

endmodule

// File: rtl/dot_composer.sv
module dot_composer
    import dc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic [3:0]         digit_idx,
    output logic [3:0]         code_raddr,
    input  logic [7:0]         code_rdata,
    input  logic [1:0]         sym_rdata,
    output logic [2:0]         upat_raddr,
    input  logic [34:0]        upat_rdata,
    input  logic               light_lo,
    input  logic               light_hi,
    output logic [34:0]        seg_o,
    output logic [1:0]         sym_o
);

    fetch_t stage;
    cols_t  rom_cols;
    cols_t  sel_cols;
    dots_t  dots;
    drive_t raw_drive;
    drive_t final_drive;
    light_e mode;

    dc_fetch i_fetch (
        .clk        (clk),
        .digit_idx  (digit_idx),
        .code_rdata (code_rdata),
        .sym_rdata  (sym_rdata),
        .code_raddr (code_raddr),
        .upat_raddr (upat_raddr),
        .stage_q    (stage)
    );

    dc_glyph_rom i_rom (
        .code (stage.code),
        .cols (rom_cols)
    );

    assign sel_cols = is_user_code(stage.code) ? cols_t'(upat_rdata) : rom_cols;

    dc_dot_map i_map (
        .cols (sel_cols),
        .dots (dots)
    );

    assign mode           = light_decode(light_lo, light_hi);
    assign raw_drive.dots = dots;
    assign raw_drive.sym  = stage.sym;

    dc_light i_light (
        .mode   (mode),
        .raw    (raw_drive),
        .forced (final_drive)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_o <= '0;
            sym_o <= '0;
        end else if (adv) begin
            seg_o <= final_drive.dots;
            sym_o <= final_drive.sym;
        end
    end

endmodule

// File: rtl/dc_checker.sv
module dc_checker (
    input logic        clk,
    input logic        rst,
    input logic        adv,
    input logic [1:0]  sym_rdata,
    input logic        light_lo,
    input logic        light_hi,
    input logic [34:0] seg_o,
    input logic [1:0]  sym_o
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (seg_o == '0 && sym_o == '0));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(seg_o) && $stable(sym_o)));

    // R6
    dark_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && light_lo && !light_hi) |=> (seg_o == '0 && sym_o == '0));

    // R7
    bright_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && light_hi) |=> (seg_o == '1 && sym_o == '1));

    // R5
    sym_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !light_lo && !light_hi) |=> (sym_o == $past(sym_rdata, 2)));

endmodule

bind dot_composer dc_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .sym_rdata (sym_rdata),
    .light_lo  (light_lo),
    .light_hi  (light_hi),
    .seg_o     (seg_o),
    .sym_o     (sym_o)
);

// File: tb/test_dot_composer.sv
module test_dot_composer;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv = 1'b0;
    logic [3:0]  digit_idx = '0;
    logic [3:0]  code_raddr;
    logic [7:0]  code_rdata = '0;
    logic [1:0]  sym_rdata = '0;
    logic [2:0]  upat_raddr;
    logic [34:0] upat_rdata = '0;
    logic        light_lo = 1'b0;
    logic        light_hi = 1'b0;
    logic [34:0] seg_o;
    logic [1:0]  sym_o;

    logic [7:0]  codes [16];
    logic [1:0]  syms  [16];
    logic [34:0] upat  [8];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Synchronous memories, one cycle of read latency.
    always @(posedge clk) begin
        code_rdata <= codes[code_raddr];
        sym_rdata  <= syms[code_raddr];
        upat_rdata <= upat[upat_raddr];
    end

    dot_composer i_dot_composer (
        .clk        (clk),
        .rst        (rst),
        .adv        (adv),
        .digit_idx  (digit_idx),
        .code_raddr (code_raddr),
        .code_rdata (code_rdata),
        .sym_rdata  (sym_rdata),
        .upat_raddr (upat_raddr),
        .upat_rdata (upat_rdata),
        .light_lo   (light_lo),
        .light_hi   (light_hi),
        .seg_o      (seg_o),
        .sym_o      (sym_o)
    );

    function automatic logic [34:0] slot_pattern(int s, bit inv);
        logic [34:0] p;
        p = 35'h2_5A3C_96E1 ^ (35'(s) * 35'h0_1357_9BDF);
        return inv ? ~p : p;
    endfunction

    // Column k, row r of the pattern for code c (R2, R3), placed per R4.
    function automatic logic [34:0] expect_seg(logic [7:0] c);
        logic [34:0] e;
        logic        b;
        e = '0;
        for (int k = 0; k < 5; k++) begin
            for (int r = 0; r < 7; r++) begin
                if (c < 8)
                    b = upat[c[2:0]][7*k + r];
                else
                    b = c[(r - k + 8) % 8];
                e[k + 5*r] = b;
            end
        end
        return e;
    endfunction

    task automatic check35(string tag, logic [34:0] act, logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s seg got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check2(string tag, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s sym got %h expected %h", tag, act, exp);
        end
    endtask

    // Index before edge 1, strobe at edge 3, sample at the next falling edge (R8).
    task automatic show(logic [3:0] d);
        @(negedge clk);
        digit_idx = d;
        adv = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        adv = 1'b1;
        @(posedge clk);
        @(negedge clk);
        adv = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [34:0] held_seg;
        logic [1:0]  held_sym;
        for (int i = 0; i < 16; i++) begin
            codes[i] = 8'(8'h41 + i);
            syms[i]  = 2'(i);
        end
        for (int s = 0; s < 8; s++) upat[s] = slot_pattern(s, 1'b0);

        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: outputs low in reset
        check35("R1", seg_o, '0);
        check2("R1", sym_o, '0);
        rst = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        // R1: still low with no strobe after reset
        check35("R1", seg_o, '0);
        check2("R1", sym_o, '0);

        // R2 R3 R5: every code value through every digit position
        for (int c = 0; c < 256; c++) begin
            logic [3:0] d;
            d = 4'(c);
            if (c == 128)
                for (int s = 0; s < 8; s++) upat[s] = slot_pattern(s, 1'b1);
            @(negedge clk);
            codes[d] = 8'(c);
            syms[d]  = 2'(c) ^ 2'(c >> 4);
            show(d);
            check35((c < 8) ? "R2" : "R3", seg_o, expect_seg(8'(c)));
            check2("R5", sym_o, syms[d]);
        end

        // R4: walk a single dot through a user pattern word
        codes[3] = 8'h00;
        for (int i = 0; i < 35; i++) begin
            logic [34:0] e;
            @(negedge clk);
            upat[0] = 35'd1 << i;
            e = 35'd1 << ((i / 7) + 5 * (i % 7));
            show(4'd3);
            check35("R4", seg_o, e);
        end

        // R8: outputs hold while inputs and memories move without a strobe
        codes[5] = 8'hC3;
        syms[5]  = 2'd2;
        show(4'd5);
        held_seg = seg_o;
        held_sym = sym_o;
        check35("R8", held_seg, expect_seg(8'hC3));
        @(negedge clk);
        digit_idx = 4'd9;
        codes[5] = 8'h1E;
        syms[5]  = 2'd1;
        light_hi = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check35("R8", seg_o, held_seg);
        check2("R8", sym_o, held_sym);
        light_hi = 1'b0;

        // R7: bright forces high, with and without dark also set
        for (int lo = 0; lo < 2; lo++) begin
            @(negedge clk);
            light_hi = 1'b1;
            light_lo = 1'(lo);
            codes[7] = 8'h00;
            syms[7]  = 2'd0;
            upat[0]  = '0;
            show(4'd7);
            check35("R7", seg_o, '1);
            check2("R7", sym_o, 2'd3);
        end

        // R6: dark alone forces low
        @(negedge clk);
        light_hi = 1'b0;
        light_lo = 1'b1;
        codes[8] = 8'hFF;
        syms[8]  = 2'd3;
        show(4'd8);
        check35("R6", seg_o, '0);
        check2("R6", sym_o, 2'd0);

        // Back to normal mode (R3, R5)
        @(negedge clk);
        light_lo = 1'b0;
        show(4'd8);
        check35("R3", seg_o, expect_seg(8'hFF));
        check2("R5", sym_o, 2'd3);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule